// File: doc/BRIEF.md
# First-Pulse High-Side On-Time Extender

This block sits between the on-time generator of an active-clamp flyback controller and the high-side gate command. It turns each pulse request into a high-side pulse whose length is the commanded on-time in clock cycles. It also watches the control-mode code. While the controller is in its low-power mode, the clamp capacitor charges above the reflected output voltage. For that reason, the first high-side pulse after the controller moves from low-power mode into burst mode is stretched by a programmable fraction of the commanded on-time, about 1.4 times. This discharges the clamp more gently before the switch opens.

The stretch factor is a fixed-point constant applied by shift-add. The result saturates at the largest count the width counter can hold. Only that one pulse is stretched, and a one-cycle flag marks its first cycle. Every other pulse passes at its commanded width. In low-power mode the high-side output is held off.

Top module: `hs_first_pulse_stretch`

## Requirements
- R1: While `mode_i` is the low-power code (2'b10) at a clock edge, `hs_gate_o` is low in the following cycle. A pulse already running is cut off, and requests are ignored.
- R2: Outside low-power mode, a request with a nonzero `on_time_i` is taken while the gate is low. `hs_gate_o` then rises in the cycle after the request and stays high for exactly `on_time_i` cycles.
- R3: A stretched pulse lasts `on_time_i + floor(on_time_i * SCALE_Q / 2^FRAC_W)` cycles, saturating at `2^CNT_W - 1`. The default is SCALE_Q = 90 and FRAC_W = 6.
- R4: Only a move from the low-power code (2'b10) to the burst code (2'b01) arms the stretch. A move from low-power to the amplitude-modulation code (2'b00) does not arm it.
- R5: `ext_pulse_o` is high for exactly one cycle, namely the first high cycle of a stretched pulse. It is never high for a plain pulse.
- R6: After the stretched pulse, all later pulses use the plain commanded width until the stretch is armed again.
- R7: If the mode returns to low-power before any pulse has started, the arm is cancelled.
- R8: A request that arrives while a pulse is running is ignored. The running pulse keeps its width.
- R9: A request with `on_time_i` = 0 produces no pulse and does not consume the arm.
- R10: During reset `hs_gate_o` and `ext_pulse_o` are low and the arm is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Control mode: 00 amplitude modulation, 01 burst, 10 low-power, 11 passes as 00 |
| pulse_req_i | input | 1 | One-cycle pulse request strobe |
| on_time_i | input | CNT_W | Commanded on-time in clock cycles |
| hs_gate_o | output | 1 | High-side gate command |
| ext_pulse_o | output | 1 | Marks the first cycle of a stretched pulse |

## Verification
The bench builds the block with CNT_W = 8 and the default 90/64 scale. Every stretched width therefore fits in a few hundred cycles. The saturation corner at 255 is reached from commanded on-times above about 106. It sweeps the commanded on-time across the whole 8-bit range in both plain and stretched form and compares each measured width with the arithmetic formula. Directed mode sequences cover arming by a low-power-to-burst move only, cancellation of the arm, zero on-time requests, mid-pulse requests and cut-off on entry to low-power mode.

// File: rtl/hs_stretch_pkg.sv
package hs_stretch_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_AMPL  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_LOWP  = 2'b10,
    MODE_RSVD  = 2'b11
  } ctl_mode_e;
endpackage

// File: rtl/hs_mode_tracker.sv
module hs_mode_tracker
  import hs_stretch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              consume_i,
  output logic              arm_o
);
  logic [MODE_W-1:0] prev_q;
  logic              armed_q;
  logic              enter_burst;
  logic              in_lowp;

  assign in_lowp     = (mode_i == MODE_LOWP);
  assign enter_burst = (prev_q == MODE_LOWP) && (mode_i == MODE_BURST);
  assign arm_o       = armed_q | enter_burst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= MODE_AMPL;
      armed_q <= 1'b0;
    end else begin
      prev_q <= mode_i;
      if (in_lowp)          armed_q <= 1'b0;
      else if (consume_i)   armed_q <= 1'b0;
      else if (enter_burst) armed_q <= 1'b1;
    end
  end

  p_lowp_disarms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lowp |=> !armed_q);
  p_use_clears_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !armed_q);
endmodule

// File: rtl/hs_width_calc.sv
module hs_width_calc #(
  parameter int CNT_W   = 12,
  parameter int SCALE_W = 7,
  parameter int SCALE_Q = 90,
  parameter int FRAC_W  = 6
) (
  input  logic [CNT_W-1:0] on_i,
  output logic [CNT_W-1:0] ext_o
);
  localparam int PW = CNT_W + SCALE_W;
  localparam logic [SCALE_W-1:0] SCALE_V = SCALE_W'(SCALE_Q);
  localparam logic [PW:0] SAT = (PW+1)'((1 << CNT_W) - 1);

  logic [PW-1:0] pp [SCALE_W];
  logic [PW-1:0] prod;
  logic [PW:0]   total;

  // shift-add multiply by the constant scale
  for (genvar i = 0; i < SCALE_W; i++) begin : g_pp
    if (SCALE_V[i]) begin : g_on
      assign pp[i] = PW'(on_i) << i;
    end else begin : g_off
      assign pp[i] = '0;
    end
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < SCALE_W; i++) prod = prod + pp[i];
    total = (PW+1)'(on_i) + (PW+1)'(prod >> FRAC_W);
    ext_o = (total > SAT) ? {CNT_W{1'b1}} : total[CNT_W-1:0];
  end
endmodule

// File: rtl/hs_pulse_timer.sv
module hs_pulse_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             abort_i,
  output logic             gate_o
);
  logic             gate_q;
  logic [CNT_W-1:0] rem_q;

  assign gate_o = gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      rem_q  <= '0;
    end else if (abort_i) begin
      gate_q <= 1'b0;
      rem_q  <= '0;
    end else if (start_i && !gate_q) begin
      gate_q <= 1'b1;
      rem_q  <= width_i - CNT_W'(1);
    end else if (gate_q) begin
      if (rem_q == '0) gate_q <= 1'b0;
      else             rem_q  <= rem_q - CNT_W'(1);
    end
  end

  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && rem_q != '0 && !abort_i) |=> (gate_q && rem_q == $past(rem_q) - CNT_W'(1)));
  p_ends_on_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && rem_q == '0) |=> !gate_q);
endmodule

// File: rtl/hs_first_pulse_stretch.sv
module hs_first_pulse_stretch
  import hs_stretch_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int SCALE_W = 7,
  parameter int SCALE_Q = 90,
  parameter int FRAC_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pulse_req_i,
  input  logic [CNT_W-1:0]  on_time_i,
  output logic              hs_gate_o,
  output logic              ext_pulse_o
);
  logic             in_lowp;
  logic             start;
  logic             arm;
  logic             use_ext;
  logic [CNT_W-1:0] ext_w;
  logic [CNT_W-1:0] width;
  logic             ext_q;

  assign in_lowp = (mode_i == MODE_LOWP);
  assign start   = pulse_req_i && !hs_gate_o && !in_lowp && (on_time_i != '0);
  assign use_ext = start && arm;
  assign width   = use_ext ? ext_w : on_time_i;

  hs_mode_tracker u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .consume_i (start),
    .arm_o     (arm)
  );

  hs_width_calc #(
    .CNT_W   (CNT_W),
    .SCALE_W (SCALE_W),
    .SCALE_Q (SCALE_Q),
    .FRAC_W  (FRAC_W)
  ) u_calc (
    .on_i  (on_time_i),
    .ext_o (ext_w)
  );

  hs_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .width_i (width),
    .abort_i (in_lowp),
    .gate_o  (hs_gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= use_ext;
  end
  assign ext_pulse_o = ext_q;

  p_lowp_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lowp |=> !hs_gate_o);
  p_flag_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_pulse_o |-> (hs_gate_o && !$past(hs_gate_o)));
  p_flag_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_pulse_o |=> !ext_pulse_o);
  p_ext_not_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_w >= on_time_i);
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_gate_o && pulse_req_i) |=> !ext_pulse_o);
endmodule

// File: tb/hs_first_pulse_stretch_test.sv
`timescale 1ns/1ps
module hs_first_pulse_stretch_test;
  localparam int CNT_W = 8;
  localparam int MAXW  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             req = 1'b0;
  logic [CNT_W-1:0] on_t = '0;
  logic             gate;
  logic             ext;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hs_first_pulse_stretch #(.CNT_W(CNT_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .pulse_req_i (req),
    .on_time_i   (on_t),
    .hs_gate_o   (gate),
    .ext_pulse_o (ext)
  );

  function automatic int ext_width(input int on);
    int w;
    w = on + (on * 90) / 64;
    return (w > MAXW) ? MAXW : w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m, input int hold);
    @(negedge clk);
    mode = m;
    repeat (hold) @(negedge clk);
  endtask

  // request one pulse; measure its width and first-cycle flag
  task automatic fire(input int on, input int exp_w, input bit exp_ext, input string tag);
    int w;
    bit first_ext;
    @(negedge clk);
    on_t = CNT_W'(on);
    req  = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (exp_w == 0) begin
      for (int k = 0; k < 3; k++) begin
        check(gate == 1'b0, {tag, " no pulse"}, int'(gate), 0);
        @(negedge clk);
      end
    end else begin
      first_ext = ext;
      w = 0;
      while (gate && w < 400) begin
        w++;
        @(negedge clk);
        if (gate) check(ext == 1'b0, {tag, " R5 flag one cycle"}, int'(ext), 0);
      end
      check(w == exp_w, {tag, " width"}, w, exp_w);
      check(first_ext == exp_ext, {tag, " R5 flag"}, int'(first_ext), int'(exp_ext));
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(gate == 1'b0, "R10 gate in reset", int'(gate), 0);
    check(ext == 1'b0, "R10 flag in reset", int'(ext), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gate == 1'b0, "R10 gate after reset", int'(gate), 0);

    // R2 plain widths in amplitude-modulation mode
    for (int on = 1; on <= 40; on++) fire(on, on, 1'b0, "R2 ampl");
    fire(MAXW, MAXW, 1'b0, "R2 ampl max");

    // R3 R4 R6 sweep: low-power to burst, stretched then plain
    for (int on = 1; on <= MAXW; on += 6) begin
      set_mode(2'b10, 3);
      set_mode(2'b01, 0);
      fire(on, ext_width(on), 1'b1, "R3 R4 stretched");
      fire(on, on, 1'b0, "R6 next plain");
    end
    set_mode(2'b10, 2);
    set_mode(2'b01, 1);
    fire(MAXW, MAXW, 1'b1, "R3 saturate");
    fire(200, 200, 1'b0, "R6 after saturate");

    // R4 low-power to amplitude modulation does not arm
    set_mode(2'b10, 3);
    set_mode(2'b00, 1);
    fire(20, 20, 1'b0, "R4 lowp to ampl");
    set_mode(2'b01, 1);
    fire(20, 20, 1'b0, "R4 ampl to burst");

    // R7 cancel: burst armed, back to low-power, then out to ampl
    set_mode(2'b10, 3);
    set_mode(2'b01, 2);
    set_mode(2'b10, 2);
    set_mode(2'b00, 1);
    fire(30, 30, 1'b0, "R7 arm cancelled");

    // R9 zero on-time keeps the arm
    set_mode(2'b10, 3);
    set_mode(2'b01, 1);
    fire(0, 0, 1'b0, "R9 zero request");
    fire(10, ext_width(10), 1'b1, "R9 arm kept");

    // R1 requests ignored in low-power mode
    set_mode(2'b10, 2);
    fire(15, 0, 1'b0, "R1 lowp request");

    // R1 running pulse cut off on entering low-power
    set_mode(2'b00, 1);
    @(negedge clk);
    on_t = 8'd40; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    check(gate == 1'b1, "R1 pulse running", int'(gate), 1);
    mode = 2'b10;
    @(negedge clk);
    check(gate == 1'b0, "R1 cut off", int'(gate), 0);
    repeat (5) @(negedge clk);
    check(gate == 1'b0, "R1 held off", int'(gate), 0);

    // R8 mid-pulse request ignored
    set_mode(2'b00, 1);
    @(negedge clk);
    on_t = 8'd12; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    w = 0;
    while (gate && w < 400) begin
      w++;
      if (w == 4) begin on_t = 8'd50; req = 1'b1; end
      else req = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    check(w == 12, "R8 width kept", w, 12);
    @(negedge clk);
    check(gate == 1'b0, "R8 no retrigger", int'(gate), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule